// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block decides whether an interrupt target addresses one hardware thread, and at which context level. A target is a block number plus a virtual processor index, joined into a 24-bit CAM value. The thread keeps three stored context words, for the hypervisor pool, the OS and the user level. It also keeps a valid bit for its hardware physical level. A fourth CAM line, for the physical level, is built from the chip block id and the thread number.

On a request strobe the block compares the target with every level and registers the result one clock later as a hit flag and a two-bit level code. Two modes exist. In the specific-target mode the levels are ranked and the highest-ranked hit wins. In the user mode the target must match the OS line and a logical-server number must also match. The logical-server ignore mode is not supported and always reports no match.

Top module: `tctx_cam_match`

## Requirements
- R1: After reset, `hit` is 0 and `lvl` is 0.
- R2: `hit` and `lvl` change only on the rising clock edge at which `req` is 1, and they then show the result for the inputs present at that edge. While `req` is 0 they hold their values.
- R3: Each stored context word arrives in big-endian byte order. Byte k of the word, with k=0 the most significant byte, sits on port bits [8k+7:8k]. After the bytes are reordered, bit 31 is the level's valid bit and bits 30:0 are the level's field.
- R4: With `fmt`=0 and `ign`=1 there is never a match: `hit`=0 and `lvl`=0.
- R5: With `fmt`=0 and `ign`=0 the levels are ranked hardware physical, then pool, then OS, and the first one that matches is reported. The level codes are 3 for hardware physical, 2 for pool, 1 for OS and 0 for user.
- R6: The hardware physical level matches when `hw_valid` is 1 and the target CAM equals the built line. The built line has `chip_blk` as its block field. Its index field has bit 7 set and `thr_num[6:0]` in bits 6:0, with all other index bits 0.
- R7: The pool level and the OS level each match when their valid bit is 1 and their 31-bit field equals the target CAM {`tgt_blk`, `tgt_idx`} zero-extended. A set bit in field bits 30:24 therefore prevents a match.
- R8: With `fmt`=1 the result is a user match, with `hit`=1 and `lvl`=0, only when all four of these hold: the OS level is valid, the OS field equals the target CAM, the user word is valid, and the user field (bits 30:0) equals `ls_num` zero-extended. In this mode the hardware physical and pool levels are never reported, and `ign` has no effect.
- R9: When no level matches, `hit` is 0 and `lvl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; a match is evaluated on each edge where it is high |
| fmt | input | 1 | 0 selects specific-target matching, 1 selects the user-level rule |
| ign | input | 1 | Logical-server ignore flag (unsupported mode when `fmt`=0) |
| tgt_blk | input | 4 | Target block number |
| tgt_idx | input | 20 | Target virtual processor index |
| ls_num | input | 12 | Logical-server number used by the user rule |
| chip_blk | input | 4 | Block id of this chip |
| thr_num | input | 7 | Thread number within the chip |
| hw_valid | input | 1 | Valid bit of the hardware physical level |
| pool_ctx | input | 32 | Pool context word, big-endian |
| os_ctx | input | 32 | OS context word, big-endian |
| usr_ctx | input | 32 | User context word, big-endian |
| hit | output | 1 | Registered match flag |
| lvl | output | 2 | Registered matched level code |

## Verification
The bench makes several levels match at once, with one and then another of their valid bits cleared. A ranking bug would therefore report pool or OS where hardware physical belongs. It also feeds a context word without the byte reordering and a field with reserved bits set. A design that compares the words as they arrive, or compares only the low 24 bits, would then report a false hit. For the built hardware line, a target index without bit 7 must miss, which catches a design that does not insert that marker bit. Each of the four user-rule conditions is failed in turn, and a target that matches only the hardware physical level is tried in user mode, which exposes a design that lets that level through. Other checks exercise the ignore mode and confirm that the outputs hold between requests.

// File: rtl/tctx_cam_match.sv
module tctx_cam_match #(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 20,
  parameter int TID_W  = 7,
  parameter int LS_W   = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              fmt,
  input  logic              ign,
  input  logic [BLK_W-1:0]  tgt_blk,
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [LS_W-1:0]   ls_num,
  input  logic [BLK_W-1:0]  chip_blk,
  input  logic [TID_W-1:0]  thr_num,
  input  logic              hw_valid,
  input  logic [WORD_W-1:0] pool_ctx,
  input  logic [WORD_W-1:0] os_ctx,
  input  logic [WORD_W-1:0] usr_ctx,
  output logic              hit,
  output logic [1:0]        lvl
);

  localparam int CAM_W = BLK_W + IDX_W;
  localparam int FLD_W = WORD_W - 1;
  localparam int NB    = WORD_W / 8;
  localparam int NCTX  = 3;
  localparam int C_USR = 0;
  localparam int C_OS  = 1;
  localparam int C_POOL = 2;
  localparam logic [1:0] L_USR = 2'd0, L_OS = 2'd1, L_POOL = 2'd2, L_HW = 2'd3;

  logic [WORD_W-1:0] raw [NCTX];
  logic [WORD_W-1:0] be  [NCTX];

  assign raw[C_USR]  = usr_ctx;
  assign raw[C_OS]   = os_ctx;
  assign raw[C_POOL] = pool_ctx;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign be[c][8*b +: 8] = raw[c][WORD_W-8-8*b +: 8];
    end
  end

  logic [CAM_W-1:0] tgt_cam, hw_cam;
  logic [IDX_W-1:0] hw_idx;
  logic             m_hw, m_pool, m_os, m_usr;
  logic             hit_n;
  logic [1:0]       lvl_n;

  assign tgt_cam = {tgt_blk, tgt_idx};
  assign hw_idx  = (IDX_W'(1) << TID_W) | IDX_W'(thr_num);
  assign hw_cam  = {chip_blk, hw_idx};

  assign m_hw   = hw_valid && (tgt_cam == hw_cam);
  assign m_pool = be[C_POOL][FLD_W] && (be[C_POOL][FLD_W-1:0] == FLD_W'(tgt_cam));
  assign m_os   = be[C_OS][FLD_W]   && (be[C_OS][FLD_W-1:0]   == FLD_W'(tgt_cam));
  assign m_usr  = m_os && be[C_USR][FLD_W] && (be[C_USR][FLD_W-1:0] == FLD_W'(ls_num));

  always_comb begin
    hit_n = 1'b0;
    lvl_n = L_USR;
    if (fmt) begin
      hit_n = m_usr;
    end else if (!ign) begin
      if (m_hw) begin
        hit_n = 1'b1;
        lvl_n = L_HW;
      end else if (m_pool) begin
        hit_n = 1'b1;
        lvl_n = L_POOL;
      end else if (m_os) begin
        hit_n = 1'b1;
        lvl_n = L_OS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      lvl <= L_USR;
    end else if (req) begin
      hit <= hit_n;
      lvl <= lvl_n;
    end
  end

  AST_IGNORE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    req && !fmt && ign |=> !hit && lvl == L_USR); // R4
  AST_NO_HIT_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> lvl == L_USR); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(hit) && $stable(lvl)); // R2
  AST_USER_MODE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    req && fmt |=> lvl == L_USR); // R8
  AST_USER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req && fmt && !(be[C_OS][FLD_W] && be[C_USR][FLD_W]) |=> !hit); // R8
  AST_HW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req && !hw_valid |=> !(hit && lvl == L_HW)); // R6
  AST_F0_NOT_USER: assert property (@(posedge clk) disable iff (!rst_n)
    req && !fmt |=> !hit || lvl != L_USR); // R5

endmodule

// File: tb/tctx_cam_match_tb.sv
`timescale 1ns/1ps
module tctx_cam_match_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, fmt = 1'b0, ign = 1'b0;
  logic [3:0]  tgt_blk = '0, chip_blk = '0;
  logic [19:0] tgt_idx = '0;
  logic [11:0] ls_num = '0;
  logic [6:0]  thr_num = '0;
  logic        hw_valid = 1'b0;
  logic [31:0] pool_ctx = '0, os_ctx = '0, usr_ctx = '0;
  logic        hit;
  logic [1:0]  lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tctx_cam_match u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .fmt(fmt), .ign(ign),
    .tgt_blk(tgt_blk), .tgt_idx(tgt_idx), .ls_num(ls_num),
    .chip_blk(chip_blk), .thr_num(thr_num), .hw_valid(hw_valid),
    .pool_ctx(pool_ctx), .os_ctx(os_ctx), .usr_ctx(usr_ctx),
    .hit(hit), .lvl(lvl)
  );

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] camw(input bit v, input logic [3:0] b, input logic [19:0] i);
    return bswap({v, 7'd0, b, i});
  endfunction

  function automatic logic [31:0] lsw(input bit v, input logic [11:0] l);
    return bswap({v, 19'd0, l});
  endfunction

  task automatic chk(input string tag, input logic h, input logic [1:0] l,
                     input logic eh, input logic [1:0] el);
    checks++;
    if (h !== eh || l !== el) begin
      errors++;
      $display("FAIL %s: hit=%0b lvl=%0d expected hit=%0b lvl=%0d", tag, h, l, eh, el);
    end
  endtask

  task automatic clear_ctx();
    fmt = 0; ign = 0; hw_valid = 0;
    pool_ctx = '0; os_ctx = '0; usr_ctx = '0;
    chip_blk = 4'h5; thr_num = 7'h43;
    tgt_blk = 4'h0; tgt_idx = '0; ls_num = '0;
  endtask

  task automatic fire();
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", hit, lvl, 1'b0, 2'd0);
  endtask

  task automatic t_os_pool();
    clear_ctx();
    tgt_blk = 4'h2; tgt_idx = 20'h1_2345;
    os_ctx = camw(1, 4'h2, 20'h1_2345);
    fire(); chk("R7 OS match", hit, lvl, 1'b1, 2'd1);
    os_ctx = camw(0, 4'h2, 20'h1_2345);
    fire(); chk("R7/R9 OS invalid", hit, lvl, 1'b0, 2'd0);
    os_ctx = camw(1, 4'h3, 20'h1_2345);
    fire(); chk("R7 OS block mismatch", hit, lvl, 1'b0, 2'd0);
    os_ctx = bswap(32'h8000_0000 | 32'h0100_0000 | {8'd0, 4'h2, 20'h1_2345});
    fire(); chk("R7 reserved field bit", hit, lvl, 1'b0, 2'd0);
    os_ctx = camw(1, 4'h2, 20'h1_2345);
    pool_ctx = camw(1, 4'h2, 20'h1_2345);
    fire(); chk("R5 pool over OS", hit, lvl, 1'b1, 2'd2);
  endtask

  task automatic t_byte_order();
    clear_ctx();
    tgt_blk = 4'h0; tgt_idx = 20'h0_0123;
    os_ctx = 32'h8000_0123;
    fire(); chk("R3 unswapped word ignored", hit, lvl, 1'b0, 2'd0);
    os_ctx = 32'h2301_0080;
    fire(); chk("R3 swapped word matches", hit, lvl, 1'b1, 2'd1);
  endtask

  task automatic t_hw();
    clear_ctx();
    hw_valid = 1;
    tgt_blk = 4'h5; tgt_idx = 20'h0_00C3;
    pool_ctx = camw(1, 4'h5, 20'h0_00C3);
    os_ctx = camw(1, 4'h5, 20'h0_00C3);
    fire(); chk("R5/R6 hw wins", hit, lvl, 1'b1, 2'd3);
    tgt_idx = 20'h0_0043;
    pool_ctx = '0; os_ctx = '0;
    fire(); chk("R6 marker bit required", hit, lvl, 1'b0, 2'd0);
    tgt_idx = 20'h0_00C3; tgt_blk = 4'h6;
    fire(); chk("R6 chip block compared", hit, lvl, 1'b0, 2'd0);
    tgt_blk = 4'h5; hw_valid = 0;
    pool_ctx = camw(1, 4'h5, 20'h0_00C3);
    fire(); chk("R6 hw invalid falls to pool", hit, lvl, 1'b1, 2'd2);
    pool_ctx = camw(0, 4'h5, 20'h0_00C3);
    os_ctx = camw(1, 4'h5, 20'h0_00C3);
    fire(); chk("R5 falls to OS", hit, lvl, 1'b1, 2'd1);
  endtask

  task automatic t_ignore();
    clear_ctx();
    hw_valid = 1; tgt_blk = 4'h5; tgt_idx = 20'h0_00C3;
    os_ctx = camw(1, 4'h5, 20'h0_00C3);
    ign = 1;
    fire(); chk("R4 ignore mode no match", hit, lvl, 1'b0, 2'd0);
  endtask

  task automatic t_user();
    clear_ctx();
    fmt = 1; tgt_blk = 4'h9; tgt_idx = 20'hA_BCDE; ls_num = 12'h3C5;
    os_ctx = camw(1, 4'h9, 20'hA_BCDE);
    usr_ctx = lsw(1, 12'h3C5);
    fire(); chk("R8 user match", hit, lvl, 1'b1, 2'd0);
    ign = 1;
    fire(); chk("R8 ign no effect in user mode", hit, lvl, 1'b1, 2'd0);
    ign = 0; ls_num = 12'h3C4;
    fire(); chk("R8 ls mismatch", hit, lvl, 1'b0, 2'd0);
    ls_num = 12'h3C5; usr_ctx = lsw(0, 12'h3C5);
    fire(); chk("R8 user invalid", hit, lvl, 1'b0, 2'd0);
    usr_ctx = lsw(1, 12'h3C5); os_ctx = camw(0, 4'h9, 20'hA_BCDE);
    fire(); chk("R8 OS invalid", hit, lvl, 1'b0, 2'd0);
    os_ctx = camw(1, 4'h9, 20'hA_BCDF);
    fire(); chk("R8 OS cam mismatch", hit, lvl, 1'b0, 2'd0);
    os_ctx = '0; usr_ctx = lsw(1, 12'h3C5);
    hw_valid = 1; tgt_blk = 4'h5; tgt_idx = 20'h0_00C3;
    pool_ctx = camw(1, 4'h5, 20'h0_00C3);
    fire(); chk("R8 hw/pool not used in user mode", hit, lvl, 1'b0, 2'd0);
  endtask

  task automatic t_hold();
    clear_ctx();
    tgt_blk = 4'h1; tgt_idx = 20'h0_0077;
    pool_ctx = camw(1, 4'h1, 20'h0_0077);
    fire(); chk("R2 result after one edge", hit, lvl, 1'b1, 2'd2);
    pool_ctx = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R2 hold while idle", hit, lvl, 1'b1, 2'd2);
    req = 1'b1;
    #1;
    chk("R2 no change before edge", hit, lvl, 1'b1, 2'd2);
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    chk("R2 update at edge", hit, lvl, 1'b0, 2'd0);
  endtask

  initial begin
    clear_ctx();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_os_pool();
    t_byte_order();
    t_hw();
    t_ignore();
    t_user();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule